// File: doc/BRIEF.md
# Instruction Register with Prefetch Holding Stage

This block keeps the opcode the sequencer is currently executing, together with a one-entry holding stage for an instruction that memory delivered before it was wanted. A fetch that runs ahead, which usually happens while a load or store is still using the bus, is parked in the holding stage. A later promote strobe moves it into the instruction register without another memory access. When an exception is taken, a fixed trap opcode is forced into the instruction register. This flushes any parked instruction.

The block also presents each 8-bit memory read byte in two forms. The first is the byte widened to 16 bits with zeros. The second is a 16-bit word made of the new byte and a byte read earlier, which is held in an external byte-assembly register. All state sits behind an active-low asynchronous reset.

Top module: `ir_prefetch_unit`

## Requirements
- R1: While rst_ni is low, op_o reads 8'h00 and pf_valid_o reads 0.
- R2: A load_i strobe captures rd_data_i into op_o at the next rising clock edge, unless promote or trap wins that cycle.
- R3: A prefetch_i strobe without trap_i captures rd_data_i into the holding stage and sets pf_valid_o at the next edge. It leaves op_o unchanged.
- R4: promote_i while pf_valid_o is 1 copies the held byte into op_o and clears pf_valid_o at the same edge.
- R5: promote_i while pf_valid_o is 0 is ignored. op_o and pf_valid_o keep their values.
- R6: When promote_i with a valid held byte and load_i arrive together, op_o takes the held byte and rd_data_i is discarded.
- R7: trap_i loads TRAP_OP (default 8'hFE) into op_o and clears pf_valid_o. It wins over load_i, promote_i and prefetch_i in the same cycle.
- R8: When promote_i with a valid held byte and prefetch_i arrive together, op_o takes the old held byte, the new rd_data_i is parked, and pf_valid_o stays 1.
- R9: zext_o equals {8'h00, rd_data_i} combinationally.
- R10: word_o equals {rd_data_i, hold_byte_i} combinationally: the new byte is in bits 15:8 and the stored byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_data_i | input | 8 | Memory read byte |
| hold_byte_i | input | 8 | Previously read byte from the assembly register |
| load_i | input | 1 | Load read byte straight into the instruction register |
| prefetch_i | input | 1 | Park read byte in the holding stage |
| promote_i | input | 1 | Move parked byte into the instruction register |
| trap_i | input | 1 | Force the trap opcode |
| op_o | output | 8 | Current opcode |
| pf_valid_o | output | 1 | Holding stage occupied |
| zext_o | output | 16 | Read byte widened with zeros |
| word_o | output | 16 | New byte above stored byte |

## Verification
The strobes are driven one at a time first, which shows that each one moves only the state it owns. Promote is also tried with an empty holding stage, which tells a real transfer apart from a stale copy. The strobes are then combined in the same cycle: promote with load, promote with prefetch, and trap with all of them. These cases tell the priority order apart and show whether the valid flag is kept, cleared or re-set. The read-data forms are checked with byte pairs whose halves differ, so that a swapped or mis-extended word is caught.

// File: rtl/ir_pkg.sv
package ir_pkg;
  parameter int unsigned OP_W = 8;
  parameter logic [OP_W-1:0] TRAP_OP_DEF = 8'hFE;
endpackage

// File: rtl/ir_read_fmt.sv
module ir_read_fmt #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic [BYTE_W-1:0] rd_i,
  input  logic [BYTE_W-1:0] hold_i,
  output logic [WORD_W-1:0] zext_o,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    zext_o = {{BYTE_W{1'b0}}, rd_i};
    word_o = {rd_i, hold_i};
  end
endmodule

// File: rtl/ir_hold_reg.sv
module ir_hold_reg #(
  parameter int unsigned OP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] rd_i,
  input  logic            prefetch_i,
  input  logic            promote_i,
  input  logic            trap_i,
  output logic [OP_W-1:0] pf_data_o,
  output logic            pf_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_data_o  <= '0;
      pf_valid_o <= 1'b0;
    end else if (trap_i) begin
      pf_valid_o <= 1'b0;  // exception flushes parked fetch
    end else if (prefetch_i) begin
      pf_data_o  <= rd_i;
      pf_valid_o <= 1'b1;
    end else if (promote_i) begin
      pf_valid_o <= 1'b0;
    end
  end

  AST_TRAP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !pf_valid_o); // R7
  AST_PF_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_i && !trap_i |=> pf_valid_o && pf_data_o == $past(rd_i)); // R3
  AST_PROMOTE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promote_i && !prefetch_i && !trap_i |=> !pf_valid_o); // R4
endmodule

// File: rtl/ir_opcode_reg.sv
module ir_opcode_reg #(
  parameter int unsigned OP_W = 8,
  parameter logic [OP_W-1:0] TRAP_OP = 8'hFE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] rd_i,
  input  logic [OP_W-1:0] pf_data_i,
  input  logic            pf_valid_i,
  input  logic            load_i,
  input  logic            promote_i,
  input  logic            trap_i,
  output logic [OP_W-1:0] op_o
);
  logic take_pf;
  assign take_pf = promote_i && pf_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       op_o <= '0;
    else if (trap_i)   op_o <= TRAP_OP;
    else if (take_pf)  op_o <= pf_data_i;
    else if (load_i)   op_o <= rd_i;
  end

  AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> op_o == TRAP_OP); // R7
  AST_PROMOTE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promote_i && pf_valid_i && !trap_i |=> op_o == $past(pf_data_i)); // R4
  AST_LOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !trap_i && !(promote_i && pf_valid_i) |=> op_o == $past(rd_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i && !load_i && !(promote_i && pf_valid_i) |=> $stable(op_o)); // R5
endmodule

// File: rtl/ir_prefetch_unit.sv
module ir_prefetch_unit
  import ir_pkg::*;
#(
  parameter int unsigned BYTE_W = OP_W,
  parameter logic [BYTE_W-1:0] TRAP_OP = TRAP_OP_DEF,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic [BYTE_W-1:0] hold_byte_i,
  input  logic              load_i,
  input  logic              prefetch_i,
  input  logic              promote_i,
  input  logic              trap_i,
  output logic [BYTE_W-1:0] op_o,
  output logic              pf_valid_o,
  output logic [WORD_W-1:0] zext_o,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] pf_data;
  logic              pf_valid;

  ir_hold_reg #(.OP_W(BYTE_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_data_i),
    .prefetch_i (prefetch_i),
    .promote_i  (promote_i),
    .trap_i     (trap_i),
    .pf_data_o  (pf_data),
    .pf_valid_o (pf_valid)
  );

  ir_opcode_reg #(.OP_W(BYTE_W), .TRAP_OP(TRAP_OP)) u_op (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_data_i),
    .pf_data_i  (pf_data),
    .pf_valid_i (pf_valid),
    .load_i     (load_i),
    .promote_i  (promote_i),
    .trap_i     (trap_i),
    .op_o       (op_o)
  );

  ir_read_fmt #(.BYTE_W(BYTE_W)) u_fmt (
    .rd_i   (rd_data_i),
    .hold_i (hold_byte_i),
    .zext_o (zext_o),
    .word_o (word_o)
  );

  assign pf_valid_o = pf_valid;

  AST_PF_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promote_i && prefetch_i && !trap_i |=> pf_valid_o); // R8
endmodule

// File: tb/ir_prefetch_unit_test.sv
`timescale 1ns/1ps
module ir_prefetch_unit_test;
  localparam logic [7:0] TRAP = 8'hFE;

  typedef struct {
    logic [7:0] op;
    logic       valid;
    string      tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rd_data_i = '0, hold_byte_i = '0;
  logic        load_i = 0, prefetch_i = 0, promote_i = 0, trap_i = 0;
  logic [7:0]  op_o;
  logic        pf_valid_o;
  logic [15:0] zext_o, word_o;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [7:0] m_op = '0, m_pf = '0;
  logic       m_valid = 1'b0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  ir_prefetch_unit uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " op"}, {8'h00, op_o}, {8'h00, e.op});
      chk({e.tag, " valid"}, {15'd0, pf_valid_o}, {15'd0, e.valid});
    end
  end

  // driver: apply at falling edge, push expected state after the next rise
  task automatic step(input logic l, input logic p, input logic pr, input logic t,
                      input logic [7:0] rd, input logic [7:0] hb, input string tag);
    exp_t e;
    @(negedge clk_i);
    load_i = l; prefetch_i = p; promote_i = pr; trap_i = t;
    rd_data_i = rd; hold_byte_i = hb;
    #0.5;
    chk("R9 zext", zext_o, {8'h00, rd});
    chk("R10 word", word_o, {rd, hb});
    if (t) begin
      m_op = TRAP; m_valid = 1'b0;
    end else if (pr && m_valid) begin
      m_op = m_pf;
      if (p) begin m_pf = rd; m_valid = 1'b1; end
      else m_valid = 1'b0;
    end else begin
      if (l) m_op = rd;
      if (p) begin m_pf = rd; m_valid = 1'b1; end
    end
    e.op = m_op; e.valid = m_valid; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R1 reset op", {8'h00, op_o}, 16'h0000);
    chk("R1 reset valid", {15'd0, pf_valid_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, 0, 0, 0, 8'h12, 8'hA5, "R2 load");
    step(0, 1, 0, 0, 8'h34, 8'h5A, "R3 prefetch");
    step(0, 0, 1, 0, 8'h00, 8'hFF, "R4 promote");
    step(0, 0, 1, 0, 8'h99, 8'h01, "R5 promote empty");
    step(0, 1, 0, 0, 8'h56, 8'h80, "R3 prefetch2");
    step(1, 0, 1, 0, 8'h77, 8'h3C, "R6 promote over load");
    step(0, 1, 0, 0, 8'h9A, 8'hC3, "R3 prefetch3");
    step(0, 1, 1, 0, 8'hBC, 8'h0F, "R8 promote+prefetch");
    step(0, 0, 1, 0, 8'h01, 8'hF0, "R4 promote refill");
    step(0, 1, 0, 0, 8'h11, 8'h22, "R3 prefetch4");
    step(1, 0, 1, 1, 8'h22, 8'h44, "R7 trap wins");
    step(0, 1, 0, 1, 8'h33, 8'h66, "R7 trap flush prefetch");
    step(1, 0, 0, 0, 8'h80, 8'h7F, "R2 load after trap");
    step(0, 0, 0, 0, 8'hFF, 8'h00, "R5 idle");
    @(negedge clk_i);
    load_i = 0; prefetch_i = 0; promote_i = 0; trap_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 reset again op", {8'h00, op_o}, 16'h0000);
    chk("R1 reset again valid", {15'd0, pf_valid_o}, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule